// File: doc/BRIEF.md
# Master-Mode PCM Frame and Bit-Clock Generator

This block is the timing master of a narrow serial audio link. It divides a fast reference clock into a 50% duty bit clock and builds an 8 kHz frame around it. Each frame has 256 bit slots. One companded byte goes out and one comes in per frame, MSB first. Framing is selected by one mode input: a one-slot pulse just ahead of the word, or a pulse that spans the word.

The link carries audio only. There is no steering bit and no control word, so the parallel side just supplies a transmit byte once per frame and takes the received byte when a one-cycle valid strobe fires. The serial data output comes with an output enable for the pad. The pad is released outside the word.

Top module: `pcm_master_port`

## Requirements
- R1: `sclk` has a period of `CLK_DIV` fast clock cycles: high for the first half and low for the second.
- R2: A frame is `SLOTS` bit periods long. Slot 0 begins on a rising edge of `sclk`, and the slots are numbered from 0 at each frame start.
- R3: With `long_frame` = 0, `fsync` is high for exactly slot 0. It rises and falls together with rising edges of `sclk`.
- R4: With `long_frame` = 1, `fsync` is high for slots 1 through `WORD_W` (the data word) and low elsewhere.
- R5: `sdo_oe` is high only during slots 1 through `WORD_W`. `sdo` changes only at slot boundaries (rising `sclk`), and `sdo` is 0 while `sdo_oe` is low.
- R6: `tx_byte` is captured in the first fast cycle of each frame, and `tx_take` is high in that cycle only. It is sent MSB first: slot k carries bit `WORD_W`-k. Changes to `tx_byte` later in the frame have no effect on that frame's `sdo`.
- R7: `sdi` is sampled on each falling edge of `sclk` during slots 1 through `WORD_W`, MSB first. It is ignored in all other slots.
- R8: After the falling edge of slot `WORD_W`, `rx_valid` is high for one fast cycle. In that cycle `rx_byte` shows the assembled word, and `rx_byte` holds it until the next strobe.
- R9: While `rst_n` is low, `sclk`, `fsync`, `sdo_oe`, `sdo`, `tx_take` and `rx_valid` are all 0. The first fast cycle after release is slot 0 of a frame, with `sclk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_frame | input | 1 | 0: one-slot sync before the word; 1: sync spans the word |
| sdi | input | 1 | Serial receive data |
| tx_byte | input | WORD_W | Byte to send in the coming frame |
| sclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Frame sync |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Pad drive enable for sdo |
| tx_take | output | 1 | Strobe: tx_byte is captured this cycle |
| rx_byte | output | WORD_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_byte updated |

## Verification
The framing assertions assume `long_frame` changes only in slots where `fsync` is low in both modes. A change inside the sync slot or the word would move an `fsync` edge off the bit-clock edge. The bench switches the mode only in a mid-frame idle slot, and it runs frames in both modes, each several times. `tx_byte` is replaced partway through every word to show that the captured copy is the one sent. `sdi` toggles outside the word so that samples in the wrong slot would corrupt the received byte. The patterns include all-zero, all-one and single-bit bytes at both ends of the word.

// File: rtl/pcm_mp_pkg.sv
package pcm_mp_pkg;

  // True when a bit slot carries one of the data bits (slots 1..w).
  function automatic bit word_slot(input int unsigned slot, input int unsigned w);
    return (slot >= 1) && (slot <= w);
  endfunction

  // Data bit index carried by a slot, MSB first: slot 1 -> w-1, slot w -> 0.
  function automatic int unsigned msb_index(input int unsigned slot, input int unsigned w);
    return w - slot;
  endfunction

endpackage

// File: rtl/pcm_mp_timebase.sv
module pcm_mp_timebase #(
  parameter  int CLK_DIV = 4,
  parameter  int SLOTS   = 256,
  parameter  int WORD_W  = 8,
  localparam int PHW     = $clog2(CLK_DIV),
  localparam int SLW     = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           sclk,
  output logic           frame_start,
  output logic           smp_evt,
  output logic           in_word,
  output logic           last_bit,
  output logic           slot0,
  output logic [SLW-1:0] slot
);
  localparam int HALF = CLK_DIV / 2;
  localparam logic [PHW-1:0] PH_LAST = PHW'(CLK_DIV - 1);
  localparam logic [SLW-1:0] SL_LAST = SLW'(SLOTS - 1);

  logic [PHW-1:0] ph_q;
  logic [SLW-1:0] slot_q;
  logic           ph_wrap;

  assign ph_wrap = (ph_q == PH_LAST);

  // Reset parks the counters on the last phase of the last slot, so the
  // first edge after release opens slot 0 with a rising bit clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_LAST;
      slot_q <= SL_LAST;
    end else if (ph_wrap) begin
      ph_q   <= '0;
      slot_q <= (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      ph_q   <= ph_q + 1'b1;
    end
  end

  assign sclk        = (ph_q < PHW'(HALF)) && rst_n;
  assign frame_start = (slot_q == '0) && (ph_q == '0) && rst_n;
  assign smp_evt     = (ph_q == PHW'(HALF - 1));
  assign in_word     = pcm_mp_pkg::word_slot(32'(slot_q), WORD_W) && rst_n;
  assign last_bit    = (slot_q == SLW'(WORD_W));
  assign slot0       = (slot_q == '0) && rst_n;
  assign slot        = slot_q;

  p_rise_after_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> ($past(ph_q) == PH_LAST));

  p_fall_at_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> ($past(ph_q) == PHW'(HALF - 1)));

  p_frame_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $rose(sclk));

endmodule

// File: rtl/pcm_mp_tx.sv
module pcm_mp_tx #(
  parameter int WORD_W = 8,
  parameter int SLW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_word,
  input  logic [SLW-1:0]    slot,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int IDXW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] tx_hold;
  logic [IDXW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_hold <= '0;
    else if (frame_start) tx_hold <= tx_byte;
  end

  assign idx    = IDXW'(pcm_mp_pkg::msb_index(32'(slot), WORD_W));
  assign sdo    = in_word & tx_hold[idx];
  assign sdo_oe = in_word;

  p_hold_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(tx_hold));

  p_sdo_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> !$stable(slot));

endmodule

// File: rtl/pcm_mp_rx.sv
module pcm_mp_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_evt,
  input  logic              in_word,
  input  logic              last_bit,
  input  logic              sdi,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] shifted;

  assign shifted = {shreg, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_evt && in_word) begin
        shreg <= shifted[WORD_W-2:0];
        if (last_bit) begin
          rx_byte  <= shifted;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));

endmodule

// File: rtl/pcm_master_port.sv
module pcm_master_port #(
  parameter int CLK_DIV = 4,
  parameter int SLOTS   = 256,
  parameter int WORD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_frame,
  input  logic              sdi,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              sclk,
  output logic              fsync,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              tx_take,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int SLW = $clog2(SLOTS);

  logic           frame_start;
  logic           smp_evt;
  logic           in_word;
  logic           last_bit;
  logic           slot0;
  logic [SLW-1:0] slot;

  pcm_mp_timebase #(.CLK_DIV(CLK_DIV), .SLOTS(SLOTS), .WORD_W(WORD_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_start(frame_start),
    .smp_evt(smp_evt), .in_word(in_word), .last_bit(last_bit),
    .slot0(slot0), .slot(slot)
  );

  pcm_mp_tx #(.WORD_W(WORD_W), .SLW(SLW)) tx_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_word(in_word),
    .slot(slot), .tx_byte(tx_byte), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  pcm_mp_rx #(.WORD_W(WORD_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .smp_evt(smp_evt), .in_word(in_word),
    .last_bit(last_bit), .sdi(sdi), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  // Framing: one-slot pulse before the word, or a pulse covering the word.
  assign fsync   = long_frame ? in_word : slot0;
  assign tx_take = frame_start;

  p_sync_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(sclk));

  p_short_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !long_frame |-> !(fsync && sdo_oe));

  p_long_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (long_frame && $fell(fsync)) |-> $rose(sclk));

  p_long_covers_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    long_frame |-> (fsync == sdo_oe));

endmodule

// File: tb/pcm_master_port_tb_top.sv
module pcm_master_port_tb_top;
  localparam int DIV     = 4;
  localparam int NSLOT   = 256;
  localparam int W       = 8;
  localparam int FRAME   = DIV * NSLOT;
  localparam int NFRAMES = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, long_frame, sdi;
  logic [W-1:0] tx_byte;
  logic         sclk, fsync, sdo, sdo_oe, tx_take, rx_valid;
  logic [W-1:0] rx_byte;

  pcm_master_port #(.CLK_DIV(DIV), .SLOTS(NSLOT), .WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .long_frame(long_frame), .sdi(sdi),
    .tx_byte(tx_byte), .sclk(sclk), .fsync(fsync), .sdo(sdo),
    .sdo_oe(sdo_oe), .tx_take(tx_take), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit run   = 1'b0;
  logic [W-1:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] txp(input int f);
    case (f)
      0: return 8'hA5;
      1: return 8'hFF;
      2: return 8'h00;
      3: return 8'h81;
      4: return 8'h5A;
      5: return 8'h7E;
      default: return W'(f * 29 + 3);
    endcase
  endfunction

  function automatic logic [W-1:0] rxp(input int f);
    case (f)
      0: return 8'h3C;
      1: return 8'h00;
      2: return 8'hFF;
      3: return 8'h01;
      4: return 8'h80;
      default: return W'(f * 71 + 11);
    endcase
  endfunction

  function automatic bit sched(input int f);
    return ((f >= 3) && (f <= 5)) || (f >= 8);
  endfunction

  // Reference timing taken from the requirements: cycle n after release.
  task automatic cmp(input int n, input bit sel);
    int m, f, slot, ph;
    bit e_sclk, e_word, e_fs, e_sdo, e_val, e_take;
    logic [W-1:0] b;
    if (n < 0) begin
      e_sclk = 0; e_word = 0; e_fs = 0; e_sdo = 0; e_val = 0; e_take = 0;
    end else begin
      m = n % FRAME; f = n / FRAME; slot = m / DIV; ph = m % DIV;
      e_sclk = (ph < DIV / 2);
      e_word = (slot >= 1) && (slot <= W);
      e_fs   = sel ? e_word : (slot == 0);
      b      = txp(f);
      e_sdo  = e_word ? b[W - slot] : 1'b0;
      e_val  = (slot == W) && (ph == DIV / 2);
      e_take = (m == 0);
    end
    check(sclk === e_sclk, "R1 R2 sclk", int'(sclk), int'(e_sclk));
    check(fsync === e_fs, sel ? "R4 fsync long" : "R3 fsync short", int'(fsync), int'(e_fs));
    check(sdo_oe === e_word, "R5 sdo_oe", int'(sdo_oe), int'(e_word));
    check(sdo === e_sdo, "R5 R6 sdo", int'(sdo), int'(e_sdo));
    check(tx_take === e_take, "R6 tx_take", int'(tx_take), int'(e_take));
    check(rx_valid === e_val, "R8 rx_valid", int'(rx_valid), int'(e_val));
  endtask

  // Driver: inputs for cycle n, plus the expected receive byte per frame.
  task automatic drive(input int n);
    int m, f, slot;
    logic [W-1:0] r;
    m = n % FRAME; f = n / FRAME; slot = m / DIV;
    if (m == 0)   tx_byte = txp(f);
    if (m == 10)  tx_byte = ~txp(f);
    if (m == 600) long_frame = sched(f + 1);
    r = rxp(f);
    if ((slot >= 1) && (slot <= W)) sdi = r[W - slot];
    else                            sdi = m[0];
    if (m == DIV) exp_q.push_back(r);
  endtask

  // Monitor: scoreboard pops on every receive strobe.
  always @(negedge clk) begin
    if (run && rx_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected rx_valid", int'(rx_byte), 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_byte === e, "R7 R8 rx_byte", int'(rx_byte), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2 watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; long_frame = 1'b0; sdi = 1'b0; tx_byte = '0;
    repeat (3) begin
      @(negedge clk);
      check(sclk === 1'b0, "R9 reset sclk", int'(sclk), 0);
      check(fsync === 1'b0, "R9 reset fsync", int'(fsync), 0);
      check(sdo_oe === 1'b0 && sdo === 1'b0, "R9 reset sdo", int'(sdo_oe), 0);
      check(rx_valid === 1'b0 && tx_take === 1'b0, "R9 reset strobes", int'(rx_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b1;
    cmp(-1, long_frame);
    for (int n = 0; n < NFRAMES * FRAME; n++) begin
      @(negedge clk);
      cmp(n, long_frame);
      drive(n);
    end
    @(negedge clk);
    check(exp_q.size() == 0, "R8 every byte delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule